// File: doc/BRIEF.md
# USB Device Interrupt Gathering and Enable Unit

This block collects the interrupt sources on the device side of a USB controller and produces one interrupt request line. The sources are both edges of the VBUS-valid indication, both edges of the OTG ID input, start-of-frame / end-of-packet received, start-of-frame / end-of-packet timeout, USB bus reset detected, and a transaction-done event for each of eight endpoints. Each source sets a sticky status bit. Software reads the status bits and clears them by writing 1. A 16-bit enable register decides which status bits may drive the request line.

The protocol engine reports each finished transaction as a one-cycle strobe. The strobe carries an endpoint number and an outcome code. The block decides from the outcome whether that endpoint's done event fires. A NAK outcome counts only when that endpoint's NAK-interrupt enable input is high.

A parameter selects the instance type:
- The primary instance implements the VBUS and ID bits.
- The secondary instance treats those two bits as reserved.

Every pin is a plain control or status signal. There is no streaming data path, so no valid/ready handshake is used and there is no back-pressure. The register port is a single-cycle write strobe with a combinational read.

Top module: `usb_dev_irq_ctrl`

## Requirements
- R1: After reset the enable register reads 0x0000, the status register reads 0x0000 and `irq` is 0.
- R2: Address 0 is the enable register. Bits 15 (VBUS), 14 (ID), 11 (frame timeout), 9 (frame received), 8 (bus reset) and 7..0 (endpoint 7..0 done) are read/write. Bits 13, 12 and 10 read 0 and ignore writes. Address 1 is the status register and uses the same bit positions.
- R3: With `PRIMARY`=0, bits 15 and 14 read 0 in both registers and ignore writes, and changes on `vbus_valid` or `otg_id` never set a status bit.
- R4: A rising or falling change of `vbus_valid` sets status bit 15. The input passes through two synchronizing flops, so the bit becomes visible three clock edges after the change and not after two.
- R5: A rising or falling change of `otg_id` sets status bit 14, with the same three-edge latency.
- R6: A one-cycle pulse sets a status bit at the next clock edge:
  - `sof_seen` sets bit 9.
  - `sof_timeout` sets bit 11.
  - `bus_reset_seen` sets bit 8.
- R7: When `txn_vld` is high, status bit `txn_ep` is set if `txn_code` is one of: 0 (ACK sent or received), 1 (STALL sent), 2 (timeout), 3 (IN exception error) or 4 (OUT exception error). Codes 6 and 7 set nothing.
- R8: Code 5 (NAK) sets bit `txn_ep` only when `ep_nak_irq_en[txn_ep]` is 1. The NAK enables of other endpoints play no part.
- R9: Status bits are set whether or not they are enabled. `irq` is 1 exactly when some status bit and its enable bit are both 1.
- R10: Writing to address 1 clears each status bit whose write-data bit is 1 and leaves the other bits unchanged. If an event sets a bit in the same cycle as its clear, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vbus_valid | input | 1 | Asynchronous VBUS-above-threshold indication |
| otg_id | input | 1 | Asynchronous OTG ID level |
| sof_seen | input | 1 | Pulse: start-of-frame / end-of-packet received |
| sof_timeout | input | 1 | Pulse: frame marker missing past the timeout |
| bus_reset_seen | input | 1 | Pulse: USB bus reset detected |
| txn_vld | input | 1 | Pulse: a transaction has finished |
| txn_ep | input | 3 | Endpoint number of the finished transaction |
| txn_code | input | 3 | Outcome code of the finished transaction |
| ep_nak_irq_en | input | 8 | Per-endpoint permission for NAK to count as done |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects the enable register, 1 selects the status register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the addressed register |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds two instances side by side from the same stimulus:
- `u_dut` with the default `PRIMARY`=1.
- `u_dut_sec` with `PRIMARY`=0.

The primary instance reaches the two-flop edge paths in both directions and the exact cycle on which they appear. The secondary instance shows that the reserved OTG bits stay at 0 under the same register writes and pin changes. A table of endpoint, outcome and NAK-enable combinations covers every outcome code. The NAK enables are laid out so that reading the wrong endpoint's enable would flip the result.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
  localparam int REG_W    = 16;
  localparam int NUM_EP   = 8;
  localparam int EP_IDX_W = $clog2(NUM_EP);
  localparam int CODE_W   = 3;

  localparam int BIT_VBUS  = 15;
  localparam int BIT_ID    = 14;
  localparam int BIT_TMO   = 11;
  localparam int BIT_SOF   = 9;
  localparam int BIT_BUSRST = 8;

  typedef enum logic [CODE_W-1:0] {
    OC_ACK     = 3'd0,
    OC_STALL   = 3'd1,
    OC_TIMEOUT = 3'd2,
    OC_IN_ERR  = 3'd3,
    OC_OUT_ERR = 3'd4,
    OC_NAK     = 3'd5,
    OC_RSV6    = 3'd6,
    OC_RSV7    = 3'd7
  } outcome_t;

  function automatic logic [REG_W-1:0] impl_mask(input bit primary);
    logic [REG_W-1:0] m;
    m = '0;
    m[NUM_EP-1:0] = '1;
    m[BIT_BUSRST] = 1'b1;
    m[BIT_SOF]    = 1'b1;
    m[BIT_TMO]    = 1'b1;
    m[BIT_ID]     = primary;
    m[BIT_VBUS]   = primary;
    return m;
  endfunction
endpackage

// File: rtl/usb_irq_sync_edge.sv
module usb_irq_sync_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] toggle_o
);
  for (genvar i = 0; i < N; i++) begin : g_line
    logic s1_q, s2_q, last_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        s1_q   <= 1'b0;
        s2_q   <= 1'b0;
        last_q <= 1'b0;
      end else begin
        s1_q   <= async_in[i];
        s2_q   <= s1_q;
        last_q <= s2_q;
      end
    end
    assign toggle_o[i] = s2_q ^ last_q;

    // R4/R5: a detected change is a single-cycle pulse
    p_toggle_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      toggle_o[i] && $stable(s1_q) |=> !toggle_o[i]);
  end
endmodule

// File: rtl/usb_irq_ep_qual.sv
module usb_irq_ep_qual
  import usb_irq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                txn_vld,
  input  logic [EP_IDX_W-1:0] txn_ep,
  input  logic [CODE_W-1:0]   txn_code,
  input  logic [NUM_EP-1:0]   nak_en,
  output logic [NUM_EP-1:0]   ep_ev
);
  outcome_t code;
  logic     is_done, is_nak;

  always_comb begin
    code    = outcome_t'(txn_code);
    is_done = (code == OC_ACK) || (code == OC_STALL) || (code == OC_TIMEOUT)
           || (code == OC_IN_ERR) || (code == OC_OUT_ERR);
    is_nak  = (code == OC_NAK);
  end

  for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
    logic hit;
    assign hit      = txn_vld && (txn_ep == EP_IDX_W'(e));
    assign ep_ev[e] = hit && (is_done || (is_nak && nak_en[e]));
  end

  // R7: a completed outcome always raises the addressed endpoint
  p_done_raises_r7: assert property (@(posedge clk) disable iff (!rst_n)
    txn_vld && (txn_code < 3'd5) |-> ep_ev[txn_ep]);
  // R8: NAK without its enable raises nothing
  p_nak_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    txn_vld && (txn_code == 3'd5) && !nak_en[txn_ep] |-> (ep_ev == '0));
  // R7: at most one endpoint per report
  p_single_ep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ep_ev));
endmodule

// File: rtl/usb_irq_sticky.sv
module usb_irq_sticky #(
  parameter int               W    = 16,
  parameter logic [W-1:0]     MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ev,
  input  logic [W-1:0] clr,
  output logic [W-1:0] st_q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (MASK[i]) begin : g_impl
      always_ff @(posedge clk) begin
        if (!rst_n) st_q[i] <= 1'b0;
        else        st_q[i] <= (st_q[i] & ~clr[i]) | ev[i];
      end
      // R9: an event is always captured
      p_event_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ev[i] |=> st_q[i]);
      // R10: a clear with no competing event empties the bit
      p_clear_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr[i] && !ev[i] |=> !st_q[i]);
    end else begin : g_rsv
      assign st_q[i] = 1'b0;
    end
  end
endmodule

// File: rtl/usb_dev_irq_ctrl.sv
module usb_dev_irq_ctrl
  import usb_irq_pkg::*;
#(
  parameter bit PRIMARY = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                vbus_valid,
  input  logic                otg_id,
  input  logic                sof_seen,
  input  logic                sof_timeout,
  input  logic                bus_reset_seen,
  input  logic                txn_vld,
  input  logic [EP_IDX_W-1:0] txn_ep,
  input  logic [CODE_W-1:0]   txn_code,
  input  logic [NUM_EP-1:0]   ep_nak_irq_en,
  input  logic                reg_wr,
  input  logic                reg_addr,
  input  logic [REG_W-1:0]    reg_wdata,
  output logic [REG_W-1:0]    reg_rdata,
  output logic                irq
);
  localparam logic [REG_W-1:0] MASK = impl_mask(PRIMARY);

  logic [1:0]        otg_toggle;
  logic [NUM_EP-1:0] ep_ev;
  logic [REG_W-1:0]  ev_vec, clr_vec, st_q, en_q;

  usb_irq_sync_edge #(.N(2)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({vbus_valid, otg_id}),
    .toggle_o (otg_toggle)
  );

  usb_irq_ep_qual u_qual (
    .clk      (clk),
    .rst_n    (rst_n),
    .txn_vld  (txn_vld),
    .txn_ep   (txn_ep),
    .txn_code (txn_code),
    .nak_en   (ep_nak_irq_en),
    .ep_ev    (ep_ev)
  );

  always_comb begin
    ev_vec             = '0;
    ev_vec[NUM_EP-1:0] = ep_ev;
    ev_vec[BIT_BUSRST] = bus_reset_seen;
    ev_vec[BIT_SOF]    = sof_seen;
    ev_vec[BIT_TMO]    = sof_timeout;
    ev_vec[BIT_ID]     = otg_toggle[0];
    ev_vec[BIT_VBUS]   = otg_toggle[1];
    clr_vec            = (reg_wr && reg_addr) ? reg_wdata : '0;
  end

  usb_irq_sticky #(.W(REG_W), .MASK(MASK)) u_status (
    .clk   (clk),
    .rst_n (rst_n),
    .ev    (ev_vec),
    .clr   (clr_vec),
    .st_q  (st_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                   en_q <= '0;
    else if (reg_wr && !reg_addr) en_q <= reg_wdata & MASK;
  end

  assign reg_rdata = reg_addr ? st_q : en_q;
  assign irq       = |(st_q & en_q);

  // R2/R3: unimplemented positions never read back as 1
  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & ~MASK) == '0);
  // R9: a request needs both a pending bit and an enabled bit
  p_irq_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (st_q != '0) && (en_q != '0));
  // R2: an enable write lands on the next edge
  p_en_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && !reg_addr |=> en_q == ($past(reg_wdata) & MASK));
endmodule

// File: tb/usb_dev_irq_ctrl_tb.sv
module usb_dev_irq_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vbus_valid = 0, otg_id = 0, sof_seen = 0, sof_timeout = 0, bus_reset_seen = 0;
  logic txn_vld = 0;
  logic [2:0] txn_ep = 0, txn_code = 0;
  logic [7:0] ep_nak_irq_en = 0;
  logic reg_wr = 0, reg_addr = 0;
  logic [15:0] reg_wdata = 0;
  logic [15:0] rdata, rdata_sec;
  logic irq, irq_sec;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  usb_dev_irq_ctrl #(.PRIMARY(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .vbus_valid(vbus_valid), .otg_id(otg_id),
    .sof_seen(sof_seen), .sof_timeout(sof_timeout), .bus_reset_seen(bus_reset_seen),
    .txn_vld(txn_vld), .txn_ep(txn_ep), .txn_code(txn_code),
    .ep_nak_irq_en(ep_nak_irq_en), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rdata), .irq(irq));

  usb_dev_irq_ctrl #(.PRIMARY(1'b0)) u_dut_sec (
    .clk(clk), .rst_n(rst_n), .vbus_valid(vbus_valid), .otg_id(otg_id),
    .sof_seen(sof_seen), .sof_timeout(sof_timeout), .bus_reset_seen(bus_reset_seen),
    .txn_vld(txn_vld), .txn_ep(txn_ep), .txn_code(txn_code),
    .ep_nak_irq_en(ep_nak_irq_en), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rdata_sec), .irq(irq_sec));

  // {ep[7:5], code[4:2], nak_en_of_ep[1], expect_set[0]}
  localparam logic [7:0] VEC [0:11] = '{
    {3'd0, 3'd0, 1'b0, 1'b1},
    {3'd1, 3'd1, 1'b0, 1'b1},
    {3'd2, 3'd2, 1'b0, 1'b1},
    {3'd3, 3'd3, 1'b0, 1'b1},
    {3'd4, 3'd4, 1'b0, 1'b1},
    {3'd5, 3'd5, 1'b0, 1'b0},
    {3'd6, 3'd5, 1'b1, 1'b1},
    {3'd7, 3'd6, 1'b1, 1'b0},
    {3'd7, 3'd7, 1'b0, 1'b0},
    {3'd7, 3'd0, 1'b0, 1'b1},
    {3'd3, 3'd5, 1'b1, 1'b1},
    {3'd0, 3'd5, 1'b0, 1'b0}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [15:0] d, output logic [15:0] ds);
    @(negedge clk);
    reg_addr = a;
    #1;
    d = rdata; ds = rdata_sec;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: sof_seen = 1'b1;
      1: sof_timeout = 1'b1;
      default: bus_reset_seen = 1'b1;
    endcase
    @(negedge clk);
    sof_seen = 0; sof_timeout = 0; bus_reset_seen = 0;
  endtask

  task automatic otg_change(input bit is_vbus, input logic lvl, input logic [15:0] bitv, input string tag);
    @(negedge clk);
    reg_addr = 1'b1;
    if (is_vbus) vbus_valid = lvl; else otg_id = lvl;
    repeat (2) @(negedge clk);
    #1 chk({tag, " not yet after two edges"}, rdata, 16'h0000);
    @(negedge clk);
    #1 chk({tag, " set after three edges"}, rdata, bitv);
    chk("R3 secondary ignores OTG change", rdata_sec, 16'h0000);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] d, ds;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(1'b0, d, ds); chk("R1 enable after reset", d, 16'h0000);
    rd(1'b1, d, ds); chk("R1 status after reset", d, 16'h0000);
    chk("R1 irq after reset", {15'd0, irq}, 16'h0000);

    // R2 / R3 register layout
    wr(1'b0, 16'hFFFF);
    rd(1'b0, d, ds);
    chk("R2 enable implemented bits", d, 16'hCBFF);
    chk("R3 secondary enable bits", ds, 16'h0BFF);
    wr(1'b0, 16'h0000);
    rd(1'b0, d, ds); chk("R2 enable cleared", d, 16'h0000);

    // R4 VBUS both edges
    otg_change(1'b1, 1'b1, 16'h8000, "R4 VBUS rise");
    wr(1'b1, 16'hFFFF);
    otg_change(1'b1, 1'b0, 16'h8000, "R4 VBUS fall");
    wr(1'b1, 16'hFFFF);
    // R5 ID both edges
    otg_change(1'b0, 1'b1, 16'h4000, "R5 ID rise");
    wr(1'b1, 16'hFFFF);
    otg_change(1'b0, 1'b0, 16'h4000, "R5 ID fall");
    wr(1'b1, 16'hFFFF);

    // R6 frame and reset pulses
    pulse(0); rd(1'b1, d, ds); chk("R6 frame received bit 9", d, 16'h0200);
    wr(1'b1, 16'hFFFF);
    pulse(1); rd(1'b1, d, ds); chk("R6 frame timeout bit 11", d, 16'h0800);
    wr(1'b1, 16'hFFFF);
    pulse(2); rd(1'b1, d, ds); chk("R6 bus reset bit 8", d, 16'h0100);
    wr(1'b1, 16'hFFFF);

    // R7 / R8 endpoint outcome table
    for (int i = 0; i < 12; i++) begin
      logic [2:0] ep;
      logic [2:0] code;
      logic nak, exp;
      {ep, code, nak, exp} = VEC[i];
      wr(1'b1, 16'hFFFF);
      @(negedge clk);
      ep_nak_irq_en = nak ? (8'd1 << ep) : ~(8'd1 << ep);
      txn_vld = 1'b1; txn_ep = ep; txn_code = code;
      @(negedge clk);
      txn_vld = 1'b0;
      rd(1'b1, d, ds);
      chk((code == 3'd5) ? "R8 NAK outcome" : "R7 endpoint outcome",
          d, exp ? (16'd1 << ep) : 16'h0000);
    end
    wr(1'b1, 16'hFFFF);

    // R9 sticky regardless of enable; irq gating
    pulse(0);
    rd(1'b1, d, ds);
    chk("R9 status set while disabled", d, 16'h0200);
    chk("R9 irq low while disabled", {15'd0, irq}, 16'h0000);
    wr(1'b0, 16'h0200); #1;
    chk("R9 irq high when enabled", {15'd0, irq}, 16'h0001);
    wr(1'b0, 16'h0100); #1;
    chk("R9 irq low with other enable", {15'd0, irq}, 16'h0000);

    // R10 write-one-to-clear
    wr(1'b1, 16'h0001);
    rd(1'b1, d, ds); chk("R10 zero bits untouched", d, 16'h0200);
    @(negedge clk);
    sof_seen = 1'b1; reg_wr = 1'b1; reg_addr = 1'b1; reg_wdata = 16'h0200;
    @(negedge clk);
    sof_seen = 1'b0; reg_wr = 1'b0;
    rd(1'b1, d, ds); chk("R10 event beats same-cycle clear", d, 16'h0200);
    wr(1'b1, 16'h0200);
    rd(1'b1, d, ds); chk("R10 clear empties bit", d, 16'h0000);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule